// File: doc/BRIEF.md
# Thread-Block Launch Dispatcher with Capacity-Gated Rotation

This block places thread-block launch requests onto a small set of streaming multiprocessors. Each request states how many threads the block needs and how many bytes of shared memory it claims. For every multiprocessor the dispatcher keeps three running totals: resident blocks, resident threads and shared memory in use. A request goes only to a multiprocessor whose three totals would all stay within their limits after the block is added.

The choice among multiprocessors rotates. A search pointer names the first candidate. The search walks forward once around the ring and takes the first multiprocessor with room. After a grant the pointer moves to the slot just past the winner. When no multiprocessor has room, the request input stays not-ready and the request waits. Completion lanes, one per multiprocessor, return a finished block's threads and shared memory, and free one block slot.

Top module: `blk_dispatcher`

## Requirements
- R1: After reset all totals are zero, the pointer is 0 and `disp_valid` is low, so the first request that is within the per-multiprocessor limits is ready at once and is granted to index 0.
- R2: A multiprocessor has room only if resident blocks + 1 <= MAX_BLK (8), resident threads + `req_threads` <= MAX_THR (1024) and shared bytes + `req_smem` <= SMEM_CAP (16384). The byte limit and the thread limit are each enforced on their own.
- R3: The search starts at the pointer and moves up through the indices, wrapping from N_SM-1 to 0. It picks the first multiprocessor with room, and the pointer then becomes (winner + 1) mod N_SM.
- R4: When no multiprocessor has room, `req_ready` is low. No dispatch is issued and no total changes, and the request is held until a completion frees room.
- R5: A handshake (`req_valid` and `req_ready` high at a clock edge) raises `disp_valid` for exactly the following cycle, with `disp_idx` equal to the granted index.
- R6: A handshake adds one block, `req_threads` threads and `req_smem` bytes to the granted multiprocessor's totals at that edge.
- R7: `cmp_valid[i]` at an edge removes one block, plus the threads and bytes in lane i of `cmp_threads` and `cmp_smem` (bits i*W and up). The freed room is visible to the decision in the next cycle, not the same one.
- R8: A completion and a grant to the same multiprocessor at the same edge are both applied to its totals.
- R9: The block limit stops placement even when the thread and byte totals leave room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Some multiprocessor has room for the current request |
| req_threads | input | 11 | Threads the requested block needs |
| req_smem | input | 15 | Shared-memory bytes the requested block needs |
| cmp_valid | input | N_SM | One completion strobe per multiprocessor |
| cmp_threads | input | N_SM*11 | Threads released, one lane per multiprocessor |
| cmp_smem | input | N_SM*15 | Shared bytes released, one lane per multiprocessor |
| disp_valid | output | 1 | A block was placed at the previous edge |
| disp_idx | output | 2 | Index of the multiprocessor that received it |

## Verification
`req_ready` is combinational: it is due in the same cycle the request is presented, and it reflects totals as they stood at the last edge. The bench samples it mid-cycle after driving new inputs. `disp_valid` and `disp_idx` come one edge after the handshake and are compared at the next falling edge. A completion changes the totals at its edge, so its effect on readiness is expected one cycle later. The bench's queue-based model applies grants and releases at the same edge so that it keeps to that lag.

// File: rtl/blk_disp_pkg.sv
package blk_disp_pkg;

  localparam int DEF_TARGETS     = 3;
  localparam int DEF_MAX_BLOCKS  = 8;
  localparam int DEF_MAX_THREADS = 1024;
  localparam int DEF_SMEM_BYTES  = 16384;

  // width of an index into n slots, never below one bit
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width of a counter that must reach cap inclusive
  function automatic int unsigned cnt_width(input int unsigned cap);
    return $clog2(cap + 1);
  endfunction

  // true when used + need stays within cap, computed without wrap
  function automatic logic has_room(input logic [31:0] used,
                                    input logic [31:0] need,
                                    input logic [31:0] cap);
    logic [32:0] total;
    total = {1'b0, used} + {1'b0, need};
    return total <= {1'b0, cap};
  endfunction

  // base + step on a ring of n slots, with base < n and step < n
  function automatic int unsigned ring_next(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned n);
    int unsigned s;
    s = base + step;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/disp_sm_track.sv
module disp_sm_track
  import blk_disp_pkg::*;
#(
  parameter int MAX_BLK  = DEF_MAX_BLOCKS,
  parameter int MAX_THR  = DEF_MAX_THREADS,
  parameter int SMEM_CAP = DEF_SMEM_BYTES,
  parameter int BLK_W    = 4,
  parameter int THR_W    = 11,
  parameter int SMEM_W   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  need_thr,
  input  logic [SMEM_W-1:0] need_smem,
  input  logic              take,
  input  logic              rel,
  input  logic [THR_W-1:0]  rel_thr,
  input  logic [SMEM_W-1:0] rel_smem,
  output logic              fit
);

  logic [BLK_W-1:0]  blk_q;
  logic [THR_W-1:0]  thr_q;
  logic [SMEM_W-1:0] smem_q;

  logic blk_ok, thr_ok, smem_ok;

  assign blk_ok  = has_room(32'(blk_q),  32'd1,           32'(MAX_BLK));
  assign thr_ok  = has_room(32'(thr_q),  32'(need_thr),   32'(MAX_THR));
  assign smem_ok = has_room(32'(smem_q), 32'(need_smem),  32'(SMEM_CAP));
  assign fit     = blk_ok & thr_ok & smem_ok;

  logic [BLK_W-1:0]  blk_add,  blk_sub;
  logic [THR_W-1:0]  thr_add,  thr_sub;
  logic [SMEM_W-1:0] smem_add, smem_sub;

  always_comb begin
    blk_add  = take ? BLK_W'(1) : '0;
    thr_add  = take ? need_thr  : '0;
    smem_add = take ? need_smem : '0;
    blk_sub  = rel  ? BLK_W'(1) : '0;
    thr_sub  = rel  ? rel_thr   : '0;
    smem_sub = rel  ? rel_smem  : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      thr_q  <= '0;
      smem_q <= '0;
    end else begin
      blk_q  <= blk_q  + blk_add  - blk_sub;
      thr_q  <= thr_q  + thr_add  - thr_sub;
      smem_q <= smem_q + smem_add - smem_sub;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(blk_q) <= 32'(MAX_BLK)) && (32'(thr_q) <= 32'(MAX_THR)) && (32'(smem_q) <= 32'(SMEM_CAP))); // R2
  AST_RELEASE_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> (blk_q != '0) && (thr_q >= rel_thr) && (smem_q >= rel_smem)); // R7
  AST_TAKE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !rel |=> blk_q == $past(blk_q) + BLK_W'(1)); // R6
  AST_BOTH_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    take && rel |=> (blk_q == $past(blk_q)) && (thr_q == $past(thr_q) + $past(need_thr) - $past(rel_thr))); // R8

endmodule

// File: rtl/disp_rr_pick.sv
module disp_rr_pick
  import blk_disp_pkg::*;
#(
  parameter int N     = DEF_TARGETS,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] start,
  input  logic [N-1:0]     cand,
  output logic             any,
  output logic [IDX_W-1:0] pick,
  output logic [N-1:0]     pick_oh
);

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int k = 0; k < N; k++) begin
      int unsigned pos;
      pos = ring_next(32'(start), 32'(k), 32'(N));
      if (!any && cand[pos]) begin
        any  = 1'b1;
        pick = IDX_W'(pos);
      end
    end
    pick_oh = '0;
    if (any) pick_oh[pick] = 1'b1;
  end

  AST_GRANT_IS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> cand[pick]); // R2
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cand[start] |-> pick == start); // R3
  AST_NO_CAND_NO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !any); // R4

endmodule

// File: rtl/blk_dispatcher.sv
module blk_dispatcher
  import blk_disp_pkg::*;
#(
  parameter int N_SM     = DEF_TARGETS,
  parameter int MAX_BLK  = DEF_MAX_BLOCKS,
  parameter int MAX_THR  = DEF_MAX_THREADS,
  parameter int SMEM_CAP = DEF_SMEM_BYTES,
  localparam int IDX_W   = idx_width(N_SM),
  localparam int BLK_W   = cnt_width(MAX_BLK),
  localparam int THR_W   = cnt_width(MAX_THR),
  localparam int SMEM_W  = cnt_width(SMEM_CAP)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [THR_W-1:0]         req_threads,
  input  logic [SMEM_W-1:0]        req_smem,
  input  logic [N_SM-1:0]          cmp_valid,
  input  logic [N_SM*THR_W-1:0]    cmp_threads,
  input  logic [N_SM*SMEM_W-1:0]   cmp_smem,
  output logic                     disp_valid,
  output logic [IDX_W-1:0]         disp_idx
);

  logic [IDX_W-1:0] rr_ptr;
  logic [N_SM-1:0]  fit_vec;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [N_SM-1:0]  pick_oh;
  logic             fire;

  assign req_ready = pick_any;
  assign fire      = req_valid & pick_any;

  for (genvar g = 0; g < N_SM; g++) begin : g_sm
    disp_sm_track #(
      .MAX_BLK (MAX_BLK),
      .MAX_THR (MAX_THR),
      .SMEM_CAP(SMEM_CAP),
      .BLK_W   (BLK_W),
      .THR_W   (THR_W),
      .SMEM_W  (SMEM_W)
    ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .need_thr (req_threads),
      .need_smem(req_smem),
      .take     (fire & pick_oh[g]),
      .rel      (cmp_valid[g]),
      .rel_thr  (cmp_threads[g*THR_W +: THR_W]),
      .rel_smem (cmp_smem[g*SMEM_W +: SMEM_W]),
      .fit      (fit_vec[g])
    );
  end

  disp_rr_pick #(
    .N    (N_SM),
    .IDX_W(IDX_W)
  ) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rr_ptr),
    .cand   (fit_vec),
    .any    (pick_any),
    .pick   (pick_idx),
    .pick_oh(pick_oh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr     <= '0;
      disp_valid <= 1'b0;
      disp_idx   <= '0;
    end else begin
      disp_valid <= fire;
      if (fire) begin
        rr_ptr   <= IDX_W'(ring_next(32'(pick_idx), 32'd1, 32'(N_SM)));
        disp_idx <= pick_idx;
      end
    end
  end

  AST_DISP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> disp_valid && (disp_idx == $past(pick_idx))); // R5
  AST_HELD_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !disp_valid); // R4
  AST_PTR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> rr_ptr == IDX_W'(ring_next(32'(disp_idx), 32'd1, 32'(N_SM)))); // R3

endmodule

// File: tb/blk_dispatcher_bench.sv
module blk_dispatcher_bench;

  localparam int NT     = 3;
  localparam int THR_W  = 11;
  localparam int SMEM_W = 15;
  localparam int IDX_W  = 2;
  localparam int LIM_B  = 8;
  localparam int LIM_T  = 1024;
  localparam int LIM_S  = 16384;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   req_valid;
  logic                   req_ready;
  logic [THR_W-1:0]       req_threads;
  logic [SMEM_W-1:0]      req_smem;
  logic [NT-1:0]          cmp_valid;
  logic [NT*THR_W-1:0]    cmp_threads;
  logic [NT*SMEM_W-1:0]   cmp_smem;
  logic                   disp_valid;
  logic [IDX_W-1:0]       disp_idx;

  always #10 clk = ~clk;

  blk_dispatcher u_blk_dispatcher (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_smem(req_smem),
    .cmp_valid(cmp_valid), .cmp_threads(cmp_threads), .cmp_smem(cmp_smem),
    .disp_valid(disp_valid), .disp_idx(disp_idx)
  );

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  string cur_tag = "R1";

  // behavioural model
  int q_thr[NT][$];
  int q_smem[NT][$];
  int m_blk[NT];
  int m_thr[NT];
  int m_smem[NT];
  int m_ptr;
  bit exp_dv;
  int exp_idx;
  bit last_fire;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // one clock of stimulus, with checks and model update
  task automatic tick(input bit v, input int thr, input int sm, input bit [NT-1:0] cv);
    bit ok;
    int g;
    bit [NT-1:0] lanes;
    @(negedge clk);
    chk(disp_valid === exp_dv, "R5 disp_valid", int'(disp_valid), int'(exp_dv));
    if (exp_dv) chk(disp_idx === IDX_W'(exp_idx), "R5 disp_idx", int'(disp_idx), exp_idx);
    req_valid   = v;
    req_threads = THR_W'(thr);
    req_smem    = SMEM_W'(sm);
    cmp_threads = '0;
    cmp_smem    = '0;
    lanes = '0;
    for (int i = 0; i < NT; i++) begin
      if (cv[i] && q_thr[i].size() > 0) begin
        lanes[i] = 1'b1;
        cmp_threads[i*THR_W +: THR_W] = THR_W'(q_thr[i][0]);
        cmp_smem[i*SMEM_W +: SMEM_W]  = SMEM_W'(q_smem[i][0]);
      end
    end
    cmp_valid = lanes;
    #5;
    ok = 1'b0;
    g  = 0;
    for (int k = 0; k < NT; k++) begin
      int p;
      p = (m_ptr + k) % NT;
      if (!ok && m_blk[p] + 1 <= LIM_B && m_thr[p] + thr <= LIM_T && m_smem[p] + sm <= LIM_S) begin
        ok = 1'b1;
        g  = p;
      end
    end
    chk(req_ready === ok, {cur_tag, " req_ready"}, int'(req_ready), int'(ok));
    @(posedge clk);
    last_fire = v && ok;
    exp_dv = last_fire;
    for (int i = 0; i < NT; i++) begin
      if (lanes[i]) begin
        m_blk[i]--;
        m_thr[i]  -= q_thr[i].pop_front();
        m_smem[i] -= q_smem[i].pop_front();
      end
    end
    if (last_fire) begin
      exp_idx = g;
      m_blk[g]++;
      m_thr[g]  += thr;
      m_smem[g] += sm;
      q_thr[g].push_back(thr);
      q_smem[g].push_back(sm);
      m_ptr = (g + 1) % NT;
    end
  endtask

  task automatic drain();
    while (q_thr[0].size() + q_thr[1].size() + q_thr[2].size() > 0)
      tick(1'b0, 0, 0, '1);
    tick(1'b0, 0, 0, '0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_threads = '0; req_smem = '0;
    cmp_valid = '0; cmp_threads = '0; cmp_smem = '0;
    for (int i = 0; i < NT; i++) begin m_blk[i] = 0; m_thr[i] = 0; m_smem[i] = 0; end
    m_ptr = 0; exp_dv = 1'b0; exp_idx = 0; last_fire = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(disp_valid === 1'b0, "R1 disp_valid after reset", int'(disp_valid), 0);

    // R1: first request ready at once and goes to index 0
    cur_tag = "R1";
    tick(1'b1, 64, 512, '0);
    tick(1'b0, 0, 0, '0);
    chk(exp_idx == 0, "R1 model first grant", exp_idx, 0);
    drain();

    // R3: rotation across the ring
    cur_tag = "R3";
    for (int n = 0; n < 7; n++) tick(1'b1, 32, 256, '0);
    tick(1'b0, 0, 0, '0);
    drain();

    // R9: block limit with threads and bytes left over, then R4 hold and R7 release
    cur_tag = "R9";
    for (int n = 0; n < 24; n++) tick(1'b1, 16, 64, '0);
    cur_tag = "R4";
    for (int n = 0; n < 4; n++) tick(1'b1, 16, 64, '0);
    cur_tag = "R7";
    tick(1'b1, 16, 64, 3'b010);
    tick(1'b1, 16, 64, '0);
    tick(1'b0, 0, 0, '0);
    drain();

    // R2: thread limit alone
    cur_tag = "R2";
    for (int n = 0; n < 9; n++) tick(1'b1, 512, 0, '0);
    tick(1'b1, 512, 0, 3'b100);
    tick(1'b1, 512, 0, '0);
    drain();

    // R2: shared-memory limit alone, including an exact-fit request
    for (int n = 0; n < 8; n++) tick(1'b1, 1, 8192, '0);
    tick(1'b1, 1, 8192, 3'b001);
    tick(1'b1, 1, 8192, '0);
    drain();
    tick(1'b1, 1, 16384, '0);
    tick(1'b1, 1, 16384, '0);
    tick(1'b1, 1, 16384, '0);
    tick(1'b1, 1, 1, '0);
    drain();

    // R8: completion and grant to the same target in one cycle
    cur_tag = "R8";
    for (int n = 0; n < 24; n++) tick(1'b1, 8, 32, '0);
    tick(1'b0, 0, 0, 3'b001);
    tick(1'b1, 8, 32, 3'b001);
    tick(1'b1, 8, 32, '0);
    tick(1'b1, 8, 32, '0);
    drain();

    // R6: mixed traffic, requests held until accepted
    cur_tag = "R6";
    begin
      bit v; int t; int s;
      v = 1'b0; t = 0; s = 0;
      for (int n = 0; n < 3000; n++) begin
        if (!v || last_fire) begin
          v = ($urandom % 10) < 7;
          t = 1 + int'($urandom % 600);
          s = int'($urandom % 9001);
        end
        tick(v, t, s, NT'({($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0}));
      end
    end
    drain();

    finish_run();
  end

endmodule